// File: doc/BRIEF.md
# External Interrupt Flag Unit

This block watches four external interrupt inputs and turns trigger conditions on them into pending flags and an interrupt request. Each input first passes through a two-flop synchroniser. The synchronised value is then compared with a copy delayed by one cycle, which gives the edges. A 2-bit mode per channel selects the trigger. Three modes are edge modes: any change, falling edge and rising edge. In these modes a detected event sets the channel's pending flag. The fourth mode is a low-level trigger. In that mode the flag is held at zero, and the request comes directly from the synchronised pin level.

The four flags sit in the low nibble of an 8-bit flag register. The upper nibble always reads as zero. Software clears a flag by writing a one to its bit. A vector-taken acknowledge that carries a channel index clears that channel's flag.

A channel requests an interrupt only when three things are true: it is pending, its own enable is set, and the global enable is set. When several channels request at once, the lowest-numbered one is reported on the index output.

Top module: `extint_flag_unit`

## Requirements
- R1: After reset all four flags read zero, the read data is 0x00 and `irq_o` is low.
- R2: Bits 7..4 of `flag_rdata_o` always read zero, even after a write of 0xFF.
- R3: The mode for channel i is `mode_i[2i+1:2i]`, with 01 = any change, 10 = falling edge and 11 = rising edge. A matching transition on `pin_i[i]` sets `flag_rdata_o[i]` so that it is visible after the third rising clock edge that follows the pin change. A transition that does not match the mode leaves the flag at zero.
- R4: Channel i requests only when it is pending, `chan_en_i[i]` is 1 and `glob_en_i` is 1. `irq_o` is the OR of all channel requests.
- R5: A one-cycle `ack_i` with `ack_idx_i` = i clears flag i and no other flag.
- R6: A write with a one in bit i of `flag_wdata_i` clears flag i. A zero in bit i leaves flag i unchanged.
- R7: Mode 00 is the low-level trigger. In this mode the flag of that channel is forced to zero, including a flag that was already set. The request equals "synchronised pin is low" gated by both enables, and it appears two rising edges after the pin changes.
- R8: If a trigger event and a clear (write or acknowledge) reach the same channel in the same cycle, the flag ends up set.
- R9: When `irq_o` is high, `irq_idx_o` gives the lowest-numbered requesting channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | Asynchronous external interrupt inputs |
| mode_i | input | 8 | Trigger mode, 2 bits per channel |
| chan_en_i | input | 4 | Per-channel interrupt enables |
| glob_en_i | input | 1 | Global interrupt enable |
| flag_wr_i | input | 1 | Write strobe for the flag register (write-one-to-clear) |
| flag_wdata_i | input | 8 | Write data for the flag register |
| flag_rdata_o | output | 8 | Flag register read value, upper nibble zero |
| ack_i | input | 1 | Vector-taken acknowledge pulse |
| ack_idx_i | input | 2 | Channel being acknowledged |
| irq_o | output | 1 | Interrupt request |
| irq_idx_o | output | 2 | Lowest-numbered requesting channel |

## Verification
The bench counts clock edges from each pin change. A design with one synchroniser stage too many or too few therefore shows its flag or level request a cycle off.

- Edges of the wrong polarity are applied to the falling-edge and rising-edge channels. A detector with swapped polarity would set a flag there.
- A write of one is made to coincide with a fresh event. A design that lets the clear win drops that interrupt.
- A flag is set and the channel is then moved to level mode. A design that only blocks new sets leaves the stale flag visible.
- Two channels are enabled together. A priority encoder that picks the highest channel reports the wrong index.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_ANY  = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_mode_e;

  // Edge event for one channel from the current and previous synchronised samples.
  function automatic logic edge_hit(trig_mode_e m, logic cur, logic prev);
    case (m)
      TRIG_ANY:  return cur ^ prev;
      TRIG_FALL: return prev & ~cur;
      TRIG_RISE: return ~prev & cur;
      default:   return 1'b0;
    endcase
  endfunction

  // Next flag value: level mode forces zero, a new event beats any clear.
  function automatic logic flag_next(logic lvl, logic evt, logic clr, logic cur);
    if (lvl)      return 1'b0;
    else if (evt) return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   W       = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      cur_q  <= {W{RST_VAL}};
      prev_q <= {W{RST_VAL}};
    end else begin
      meta_q <= async_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [2*NCH-1:0] mode_i,
  input  logic [NCH-1:0]   cur_i,
  input  logic [NCH-1:0]   prev_i,
  output logic [NCH-1:0]   evt_o,
  output logic [NCH-1:0]   lvl_mode_o,
  output logic [NCH-1:0]   lvl_act_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    trig_mode_e m;
    assign m             = trig_mode_e'(mode_i[2*i +: 2]);
    assign evt_o[i]      = edge_hit(m, cur_i[i], prev_i[i]);
    assign lvl_mode_o[i] = (m == TRIG_LOW);
    assign lvl_act_o[i]  = (m == TRIG_LOW) & ~cur_i[i];
  end
endmodule

// File: rtl/extint_flags.sv
module extint_flags
  import extint_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int REG_W = 8,
  parameter int IDXW  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   evt_i,
  input  logic [NCH-1:0]   lvl_mode_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ack_i,
  input  logic [IDXW-1:0]  ack_idx_i,
  output logic [NCH-1:0]   flag_o
);
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] clr;

  for (genvar i = 0; i < NCH; i++) begin : g_clr
    assign clr[i] = (wr_i & wdata_i[i]) | (ack_i & (ack_idx_i == IDXW'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++)
        flag_q[i] <= flag_next(lvl_mode_i[i], evt_i[i], clr[i], flag_q[i]);
    end
  end

  assign flag_o = flag_q;

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R3 / R8: an edge event (even with a clear) leaves the flag set
    a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[i] && !lvl_mode_i[i]) |=> flag_q[i]);
    // R7: level mode keeps the flag at zero
    a_r7_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_mode_i[i] |=> !flag_q[i]);
    // R5: acknowledge of this channel clears it
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_idx_i == IDXW'(i) && !evt_i[i]) |=> !flag_q[i]);
    // R6: write of one clears
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[i] && !evt_i[i]) |=> !flag_q[i]);
    // R6: write of zero leaves the flag alone
    a_r6_w0_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !wdata_i[i] && !(ack_i && ack_idx_i == IDXW'(i)) &&
       !evt_i[i] && !lvl_mode_i[i]) |=> $stable(flag_q[i]));
  end
endmodule

// File: rtl/extint_flag_unit.sv
module extint_flag_unit
  import extint_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int REG_W = 8,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   pin_i,
  input  logic [2*NCH-1:0] mode_i,
  input  logic [NCH-1:0]   chan_en_i,
  input  logic             glob_en_i,
  input  logic             flag_wr_i,
  input  logic [REG_W-1:0] flag_wdata_i,
  output logic [REG_W-1:0] flag_rdata_o,
  input  logic             ack_i,
  input  logic [IDXW-1:0]  ack_idx_i,
  output logic             irq_o,
  output logic [IDXW-1:0]  irq_idx_o
);
  // Named internal events, brought out for the assertions
  logic [NCH-1:0] pin_cur, pin_prev;
  logic [NCH-1:0] evt, lvl_mode, lvl_act;
  logic [NCH-1:0] flags, pend, req;

  function automatic logic [IDXW-1:0] lowest_set(logic [NCH-1:0] v);
    logic [IDXW-1:0] r = '0;
    for (int k = NCH - 1; k >= 0; k--)
      if (v[k]) r = IDXW'(k);
    return r;
  endfunction

  extint_sync #(.W(NCH), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i),
    .cur_o(pin_cur), .prev_o(pin_prev)
  );

  extint_detect #(.NCH(NCH)) u_detect (
    .mode_i(mode_i), .cur_i(pin_cur), .prev_i(pin_prev),
    .evt_o(evt), .lvl_mode_o(lvl_mode), .lvl_act_o(lvl_act)
  );

  extint_flags #(.NCH(NCH), .REG_W(REG_W), .IDXW(IDXW)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .lvl_mode_i(lvl_mode),
    .wr_i(flag_wr_i), .wdata_i(flag_wdata_i),
    .ack_i(ack_i), .ack_idx_i(ack_idx_i), .flag_o(flags)
  );

  assign pend         = (lvl_mode & lvl_act) | (~lvl_mode & flags);
  assign req          = pend & chan_en_i & {NCH{glob_en_i}};
  assign irq_o        = |req;
  assign irq_idx_o    = lowest_set(req);
  assign flag_rdata_o = {{(REG_W-NCH){1'b0}}, flags};

  // R4: no request without the global enable
  a_r4_glob_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> glob_en_i);
  // R4: the reported channel is individually enabled
  a_r4_chan_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> chan_en_i[irq_idx_o]);
  // R9: reported index is requesting and nothing below it requests
  a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (req[irq_idx_o] &&
               ((req & ((NCH'(1) << irq_idx_o) - NCH'(1))) == '0)));
  // R7: a level-mode request needs the synchronised pin low
  a_r7_level_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && lvl_mode[irq_idx_o]) |-> !pin_cur[irq_idx_o]);
endmodule

// File: tb/tb_extint_flag_unit.sv
`timescale 1ns/1ps
module tb_extint_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin = 4'hF;
  logic [7:0] mode = 8'hFF;
  logic [3:0] chan_en = 4'h0;
  logic       glob_en = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ack = 1'b0;
  logic [1:0] ack_idx = 2'd0;
  logic       irq;
  logic [1:0] irq_idx;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  extint_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .mode_i(mode), .chan_en_i(chan_en),
    .glob_en_i(glob_en), .flag_wr_i(wr), .flag_wdata_i(wdata),
    .flag_rdata_o(rdata), .ack_i(ack), .ack_idx_i(ack_idx),
    .irq_o(irq), .irq_idx_o(irq_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input int ch, input logic [1:0] m);
    mode[2*ch +: 2] = m;
  endtask

  task automatic bus_write(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    cyc(1);
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic t_reset;
    chk("R1 flags after reset", rdata, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);
  endtask

  task automatic t_reserved;
    bus_write(8'hFF);
    chk("R2 upper nibble zero", rdata[7:4], 4'h0);
  endtask

  task automatic t_edges;
    set_mode(0, 2'b10); set_mode(1, 2'b11); set_mode(2, 2'b01);
    cyc(1);
    pin[0] = 1'b0;                              // falling on ch0
    cyc(2); chk("R3 not yet after two edges", rdata[0], 1'b0);
    cyc(1); chk("R3 falling sets at third edge", rdata[0], 1'b1);
    bus_write(8'h01);
    chk("R6 write one clears ch0", rdata[0], 1'b0);
    pin[0] = 1'b1; cyc(4);
    chk("R3 rising ignored in falling mode", rdata[0], 1'b0);
    pin[1] = 1'b0; cyc(4);
    chk("R3 falling ignored in rising mode", rdata[1], 1'b0);
    pin[1] = 1'b1; cyc(3);
    chk("R3 rising sets ch1", rdata[1], 1'b1);
    pin[2] = 1'b0; cyc(3);
    chk("R3 any change sets ch2", rdata[2], 1'b1);
    chk("R3 flag register", rdata, 8'h06);
  endtask

  task automatic t_enables;
    chan_en = 4'hF; glob_en = 1'b0; cyc(1);
    chk("R4 global enable off", irq, 1'b0);
    chan_en = 4'h0; glob_en = 1'b1; cyc(1);
    chk("R4 channel enables off", irq, 1'b0);
    chan_en = 4'b0100; cyc(1);
    chk("R4 ch2 requests", {irq, irq_idx}, {1'b1, 2'd2});
    chan_en = 4'b0110; cyc(1);
    chk("R9 lowest channel wins", {irq, irq_idx}, {1'b1, 2'd1});
  endtask

  task automatic t_ack;
    ack = 1'b1; ack_idx = 2'd1; cyc(1);
    ack = 1'b0;
    chk("R5 ack clears only ch1", rdata, 8'h04);
    chk("R5 request moves to ch2", {irq, irq_idx}, {1'b1, 2'd2});
    bus_write(8'h00);
    chk("R6 write zero holds", rdata, 8'h04);
    bus_write(8'h04);
    chk("R6 write one clears ch2", rdata, 8'h00);
    chk("R4 no pending no request", irq, 1'b0);
  endtask

  task automatic t_level;
    chan_en = 4'b1000; glob_en = 1'b1;
    pin[3] = 1'b0; cyc(3);                      // rising mode: no event on fall
    pin[3] = 1'b1; cyc(3);
    chk("R7 ch3 flag set in rising mode", rdata[3], 1'b1);
    set_mode(3, 2'b00); cyc(1);
    chk("R7 level mode clears stale flag", rdata[3], 1'b0);
    chk("R7 pin high no request", irq, 1'b0);
    pin[3] = 1'b0; cyc(1);
    chk("R7 level not yet after one edge", irq, 1'b0);
    cyc(1);
    chk("R7 level request after two edges", {irq, irq_idx}, {1'b1, 2'd3});
    chk("R7 flag stays zero in level mode", rdata[3], 1'b0);
    pin[3] = 1'b1; cyc(2);
    chk("R7 request drops with pin", irq, 1'b0);
    set_mode(3, 2'b11); chan_en = 4'h0;
  endtask

  task automatic t_setwins;
    set_mode(0, 2'b01); cyc(1);
    pin[0] = 1'b0; cyc(3);
    chk("R8 ch0 set before race", rdata[0], 1'b1);
    pin[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr = 1'b1; wdata = 8'h01;                   // clear lands with the event
    cyc(1);
    wr = 1'b0; wdata = 8'h00;
    chk("R8 set wins over clear", rdata[0], 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_reserved();
    t_edges();
    t_enables();
    t_ack();
    t_level();
    t_setwins();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule